// File: doc/BRIEF.md
# Double-Buffered TDM Channel Address Generator

This block turns a running TDM channel count and a stream number into a 13-bit address for an external dual-port RAM. The memory holds two frame-sized halves. The serial side reads transmit bytes from one half and writes receive bytes into it. A host processor works on the other half.

The block keeps one half-select flag for reads and one for writes. Each flag flips once per frame, right after that direction has made its final access. Both flags are brought out as level outputs, so the host sees each flip as an edge.

A request gives a direction (transmit read or receive write), the current serial channel count `cur_chan` and a stream number. The block applies a fixed channel lag for writes or lead for reads, maps the result through the formula for the selected rate, and registers the address one cycle later.

Top module: `tdm_addr_gen`

## Requirements
- R1: The rate is captured from `mode_sel` only while `rst_n` is low. The encodings are:
  - 000: 2.048 Mb/s
  - 001: 4.096 Mb/s
  - 010: 8.192 Mb/s
  - any other value: mixed rate
  
  Changes on `mode_sel` after reset is released have no effect.
- R2: At 2.048 Mb/s the transmit address is 24·ch+s and the receive address is 24·ch+s+0x400. The upper half adds 0x800, and address bit 12 is always 0.
- R3: At 4.096 Mb/s the transmit address is 24·ch+s and the receive address is 24·ch+s+0x800. The upper half adds 0x1000.
- R4: At 8.192 Mb/s:
  - Streams 12..23 are read at 12·ch+(s−12).
  - Streams 0..11 are written at 12·ch+s+0x800.
  - The upper half adds 0x1000.
- R5: In mixed mode, streams 0..15 are slow streams. They are read at 16·ch+s and written at 16·ch+s+0x800, where ch = (cur_chan/4)±1 modulo 32. The upper half adds 0x1000.
- R6: In mixed mode, streams 16..23 are fast streams. They are read at 8·ch+(s−16)+0x400 and written at 8·ch+(s−16)+0xC00, with channels modulo 128. The upper half adds 0x1000.
- R7: The accessed channel depends on direction:
  - Reads use cur_chan+1 and writes use cur_chan−1, modulo the channels per frame (32, 64 or 128). This gives a two-channel gap.
  - Mixed-mode fast streams use cur_chan+4 and cur_chan−4, an eight-channel gap.
- R8: `rd_done` toggles on the same clock edge that registers the read of the last channel of the last read stream. The last read stream is 23 in every rate.
- R8 (continued): `wr_done` toggles on the same clock edge that registers the write of the last channel of the last write stream. The last write stream is 11 at 8.192 Mb/s and 23 otherwise.
- R8 (continued): No other request moves `rd_done` or `wr_done`.
- R9: Each address uses the half-select flag of its own direction, taken before any toggle caused by that same request. `blk_sel` shows the half that was used. The half bit is address bit 11 at 2.048 Mb/s and bit 12 in every other rate.
- R10: While reset is asserted, `addr`, `addr_vld`, `blk_sel`, `rd_done` and `wr_done` are all 0.
- R11: `addr_vld` is `req_vld` delayed by one clock, and the address appears in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the rate is captured while it is low |
| mode_sel | input | 3 | Rate selection code |
| req_vld | input | 1 | Access request this cycle |
| req_wr | input | 1 | 1 = receive write, 0 = transmit read |
| cur_chan | input | 7 | Current serial channel count (fast-channel units in mixed mode) |
| strm | input | 5 | Stream number 0..23 |
| addr | output | 13 | RAM address |
| addr_vld | output | 1 | Address valid |
| blk_sel | output | 1 | Buffer half used by this address |
| rd_done | output | 1 | Read half flag, toggles once per frame |
| wr_done | output | 1 | Write half flag, toggles once per frame |

## Verification
The assertions take for granted that every request names a stream valid for its direction in the captured rate. At 8.192 Mb/s that means inputs 0..11 for writes and outputs 12..23 for reads. They also take for granted that `cur_chan` stays inside the rate's channel count.

The stimulus holds to these limits by sweeping whole frames with a per-rate stream list. Each frame loop walks `cur_chan` only up to the rate's channel count. In mixed mode it issues slow-stream accesses once per group of four fast channels, which is how their channel index is formed. The mode input is deliberately moved after reset to show that the captured rate holds.

// File: rtl/tdm_ag_pkg.sv
// Package: shared rate type and decode for the TDM address generator.
package tdm_ag_pkg;

    typedef enum logic [1:0] {
        RATE_2M  = 2'd0,
        RATE_4M  = 2'd1,
        RATE_8M  = 2'd2,
        RATE_MIX = 2'd3
    } rate_e;

    // Buffer region offsets within one half.
    localparam int RX_OFS_2M  = 'h400;
    localparam int HALF_2M    = 'h800;
    localparam int RX_OFS     = 'h800;
    localparam int HALF_STD   = 'h1000;
    localparam int FAST_TX    = 'h400;

    // Map the three-bit select code to a rate; unknown codes mean mixed.
    function automatic rate_e rate_decode(input logic [2:0] sel);
        case (sel)
            3'b000:  return RATE_2M;
            3'b001:  return RATE_4M;
            3'b010:  return RATE_8M;
            default: return RATE_MIX;
        endcase
    endfunction

endpackage

// File: rtl/tdm_ag_chan.sv
// Channel offset unit: derives the channel actually accessed from the
// running serial channel count, applying a write lag or read lead and
// wrapping at the rate's channel count. Assumes cur is in range.
module tdm_ag_chan
    import tdm_ag_pkg::*;
#(
    parameter int CW         = 7,
    parameter int SW         = 5,
    parameter int LAG        = 1,
    parameter int LEAD       = 1,
    parameter int HI_LAG     = 4,
    parameter int HI_LEAD    = 4,
    parameter int LO_STREAMS = 16
) (
    input  rate_e           rate,
    input  logic            wr,
    input  logic [CW-1:0]   cur,
    input  logic [SW-1:0]   strm,
    output logic [CW-1:0]   acc_chan,
    output logic            last_chan
);
    localparam logic [CW-1:0] MASK32  = CW'(31);
    localparam logic [CW-1:0] MASK64  = CW'(63);
    localparam logic [CW-1:0] MASK128 = CW'(127);

    logic          hi;
    logic [CW-1:0] base;
    logic [CW-1:0] mask;
    logic [CW-1:0] raw;

    // Pick base count, wrap mask and offset for the stream's rate class.
    always_comb begin
        hi   = (rate == RATE_MIX) && (strm >= SW'(LO_STREAMS));
        base = ((rate == RATE_MIX) && !hi) ? (cur >> 2) : cur;
        case (rate)
            RATE_2M:  mask = MASK32;
            RATE_4M:  mask = MASK64;
            RATE_8M:  mask = MASK128;
            default:  mask = hi ? MASK128 : MASK32;
        endcase
        if (hi)
            raw = wr ? (base - CW'(HI_LAG)) : (base + CW'(HI_LEAD));
        else
            raw = wr ? (base - CW'(LAG)) : (base + CW'(LEAD));
        acc_chan  = raw & mask;
        last_chan = (acc_chan == mask);
    end

endmodule

// File: rtl/tdm_ag_addr.sv
// Address formula unit: maps (rate, direction, channel, stream, half)
// to a RAM address. Assumes the stream is legal for the direction.
module tdm_ag_addr
    import tdm_ag_pkg::*;
#(
    parameter int AW = 13,
    parameter int CW = 7,
    parameter int SW = 5
) (
    input  rate_e           rate,
    input  logic            wr,
    input  logic [CW-1:0]   chan,
    input  logic [SW-1:0]   strm,
    input  logic            blk,
    output logic [AW-1:0]   addr
);
    logic [AW-1:0] c;
    logic [AW-1:0] s;
    logic [AW-1:0] half;

    // Evaluate the per-rate address formula.
    always_comb begin
        c    = AW'(chan);
        s    = AW'(strm);
        half = blk ? AW'(HALF_STD) : '0;
        case (rate)
            RATE_2M:
                addr = c * AW'(24) + s + (wr ? AW'(RX_OFS_2M) : '0)
                     + (blk ? AW'(HALF_2M) : '0);
            RATE_4M:
                addr = c * AW'(24) + s + (wr ? AW'(RX_OFS) : '0) + half;
            RATE_8M:
                addr = c * AW'(12) + (wr ? s : s - AW'(12))
                     + (wr ? AW'(RX_OFS) : '0) + half;
            default:
                if (s >= AW'(16))
                    addr = c * AW'(8) + (s - AW'(16)) + AW'(FAST_TX)
                         + (wr ? AW'(RX_OFS) : '0) + half;
                else
                    addr = c * AW'(16) + s + (wr ? AW'(RX_OFS) : '0) + half;
        endcase
    end

endmodule

// File: rtl/tdm_ag_flags.sv
// Half-select flags: one toggle flag per direction, flipped when that
// direction completes its frame. Both reset to the lower half.
module tdm_ag_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic flip_rd,
    input  logic flip_wr,
    output logic rd_half,
    output logic wr_half
);
    // Toggle each direction's flag on its frame-complete event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_half <= 1'b0;
            wr_half <= 1'b0;
        end else begin
            if (flip_rd) rd_half <= ~rd_half;
            if (flip_wr) wr_half <= ~wr_half;
        end
    end

endmodule

// File: rtl/tdm_addr_gen.sv
// Top: double-buffered TDM address generator. Captures the rate during
// reset, computes the accessed channel and address, registers them, and
// keeps the per-direction half flags exposed as frame-done toggles.
module tdm_addr_gen
    import tdm_ag_pkg::*;
#(
    parameter int AW = 13,
    parameter int CW = 7,
    parameter int SW = 5,
    parameter int LAST_STRM    = 23,
    parameter int LAST_IN_8M   = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_sel,
    input  logic          req_vld,
    input  logic          req_wr,
    input  logic [CW-1:0] cur_chan,
    input  logic [SW-1:0] strm,
    output logic [AW-1:0] addr,
    output logic          addr_vld,
    output logic          blk_sel,
    output logic          rd_done,
    output logic          wr_done
);
    rate_e         mode_q;
    logic [CW-1:0] acc_chan;
    logic          last_chan;
    logic          last_strm;
    logic          rd_half, wr_half;
    logic          use_half;
    logic [AW-1:0] addr_d;
    logic          flip_rd, flip_wr;

    // Capture the rate only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= rate_decode(mode_sel);
    end

    tdm_ag_chan #(.CW(CW), .SW(SW)) u_chan (
        .rate      (mode_q),
        .wr        (req_wr),
        .cur       (cur_chan),
        .strm      (strm),
        .acc_chan  (acc_chan),
        .last_chan (last_chan)
    );

    // Select the direction's half and detect the frame's last access.
    always_comb begin
        use_half  = req_wr ? wr_half : rd_half;
        last_strm = (strm == ((mode_q == RATE_8M && req_wr) ?
                              SW'(LAST_IN_8M) : SW'(LAST_STRM)));
        flip_rd   = req_vld && !req_wr && last_chan && last_strm;
        flip_wr   = req_vld &&  req_wr && last_chan && last_strm;
    end

    tdm_ag_addr #(.AW(AW), .CW(CW), .SW(SW)) u_addr (
        .rate (mode_q),
        .wr   (req_wr),
        .chan (acc_chan),
        .strm (strm),
        .blk  (use_half),
        .addr (addr_d)
    );

    tdm_ag_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .flip_rd (flip_rd),
        .flip_wr (flip_wr),
        .rd_half (rd_half),
        .wr_half (wr_half)
    );

    // Register the address output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            addr_vld <= 1'b0;
            blk_sel  <= 1'b0;
        end else begin
            addr_vld <= req_vld;
            if (req_vld) begin
                addr    <= addr_d;
                blk_sel <= use_half;
            end
        end
    end

    assign rd_done = rd_half;
    assign wr_done = wr_half;

endmodule

// File: rtl/tdm_ag_chk.sv
// Checker for tdm_addr_gen, bound to every instance of the top.
module tdm_ag_chk
    import tdm_ag_pkg::*;
#(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input rate_e         rate,
    input logic          req_vld,
    input logic          req_wr,
    input logic [AW-1:0] addr,
    input logic          addr_vld,
    input logic          blk_sel,
    input logic          rd_done,
    input logic          wr_done
);
    a_r1_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(rate));

    a_r2_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && rate == RATE_2M) |-> !addr[AW-1]);

    a_r9_half_bit: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld |-> (((rate == RATE_2M) ? addr[AW-2] : addr[AW-1]) == blk_sel));

    a_r9_half_source: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && addr_vld) |->
            (blk_sel == ($past(req_wr) ? $past(wr_done) : $past(rd_done))));

    a_r11_vld_rise: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> addr_vld);

    a_r11_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !addr_vld);

    a_r8_rd_source: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(rd_done)) |-> $past(req_vld && !req_wr));

    a_r8_wr_source: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(wr_done)) |-> $past(req_vld && req_wr));

endmodule

bind tdm_addr_gen tdm_ag_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate     (mode_q),
    .req_vld  (req_vld),
    .req_wr   (req_wr),
    .addr     (addr),
    .addr_vld (addr_vld),
    .blk_sel  (blk_sel),
    .rd_done  (rd_done),
    .wr_done  (wr_done)
);

// File: tb/tdm_addr_gen_tb.sv
// Scoreboard bench: driver pushes expected results, monitor compares.
module tdm_addr_gen_tb;

    typedef struct {
        bit    vld;
        int    addr;
        bit    blk;
        bit    rd;
        bit    wr;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'b000;
    logic        req_vld = 1'b0;
    logic        req_wr = 1'b0;
    logic [6:0]  cur_chan = '0;
    logic [4:0]  strm = '0;
    logic [12:0] addr;
    logic        addr_vld, blk_sel, rd_done, wr_done;

    int    total = 0;
    int    bad = 0;
    bit    mon_on = 1'b0;
    item_t q[$];
    int    m_rate = 0;
    bit    m_rd = 0;
    bit    m_wr = 0;

    always #4 clk = ~clk;

    tdm_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .req_vld(req_vld), .req_wr(req_wr), .cur_chan(cur_chan),
        .strm(strm), .addr(addr), .addr_vld(addr_vld),
        .blk_sel(blk_sel), .rd_done(rd_done), .wr_done(wr_done)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Monitor: compare each registered result shortly after the edge.
    always @(posedge clk) begin
        #2;
        if (mon_on && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            chk(addr_vld == it.vld, "R11", "addr_vld", addr_vld, it.vld);
            if (it.vld) begin
                chk(addr == it.addr[12:0], it.tag, "addr", addr, it.addr);
                chk(blk_sel == it.blk, "R9", "blk_sel", blk_sel, it.blk);
            end
            chk(rd_done == it.rd, "R8", "rd_done", rd_done, it.rd);
            chk(wr_done == it.wr, "R8", "wr_done", wr_done, it.wr);
        end
    end

    // Reset with a given select code and check the reset state (R10).
    task automatic do_reset(logic [2:0] sel);
        mon_on  = 1'b0;
        @(negedge clk);
        rst_n    = 1'b0;
        mode_sel = sel;
        req_vld  = 1'b0;
        repeat (3) @(negedge clk);
        chk(addr == 0, "R10", "addr", addr, 0);
        chk(addr_vld == 0, "R10", "addr_vld", addr_vld, 0);
        chk(blk_sel == 0, "R10", "blk_sel", blk_sel, 0);
        chk(rd_done == 0, "R10", "rd_done", rd_done, 0);
        chk(wr_done == 0, "R10", "wr_done", wr_done, 0);
        rst_n = 1'b1;
        q.delete();
        m_rd = 0;
        m_wr = 0;
        case (sel)
            3'b000:  m_rate = 0;
            3'b001:  m_rate = 1;
            3'b010:  m_rate = 2;
            default: m_rate = 3;
        endcase
        mon_on = 1'b1;
    endtask

    // Driver: apply one access and push its expected outcome.
    task automatic issue(bit wr, int cur, int s);
        item_t it;
        int n, off, base, ch, a;
        bit hi, blk;
        hi   = (m_rate == 3) && (s >= 16);
        base = (m_rate == 3 && !hi) ? cur / 4 : cur;
        n    = (m_rate == 1) ? 64 : (m_rate == 2 || hi) ? 128 : 32;
        off  = hi ? 4 : 1;
        ch   = wr ? (base - off + n) % n : (base + off) % n;
        blk  = wr ? m_wr : m_rd;
        case (m_rate)
            0: begin a = 24*ch + s + (wr ? 'h400 : 0) + (blk ? 'h800 : 0); it.tag = "R2/R7"; end
            1: begin a = 24*ch + s + (wr ? 'h800 : 0) + (blk ? 'h1000 : 0); it.tag = "R3/R7"; end
            2: begin a = 12*ch + (wr ? s : s - 12) + (wr ? 'h800 : 0) + (blk ? 'h1000 : 0); it.tag = "R4/R7"; end
            default: begin
                if (hi) begin
                    a = 8*ch + (s - 16) + (wr ? 'hC00 : 'h400) + (blk ? 'h1000 : 0);
                    it.tag = "R6/R7";
                end else begin
                    a = 16*ch + s + (wr ? 'h800 : 0) + (blk ? 'h1000 : 0);
                    it.tag = "R5/R7";
                end
            end
        endcase
        if (ch == n - 1 && s == ((m_rate == 2 && wr) ? 11 : 23)) begin
            if (wr) m_wr = ~m_wr;
            else    m_rd = ~m_rd;
        end
        it.vld = 1; it.addr = a; it.blk = blk; it.rd = m_rd; it.wr = m_wr;
        req_vld  = 1'b1;
        req_wr   = wr;
        cur_chan = 7'(cur);
        strm     = 5'(s);
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            item_t it;
            it.vld = 0; it.addr = 0; it.blk = 0; it.rd = m_rd; it.wr = m_wr;
            it.tag = "R11";
            req_vld = 1'b0;
            q.push_back(it);
            @(negedge clk);
        end
    endtask

    // Stimulus: whole frames per rate, two frames each to see both halves.
    initial begin
        do_reset(3'b000);
        mode_sel = 3'b010;              // R1: change after reset is ignored
        issue(1'b0, 3, 5);
        issue(1'b1, 0, 7);               // R7 wrap to channel 31
        for (int f = 0; f < 2; f++)
            for (int c = 0; c < 32; c++) begin
                for (int s = 0; s < 24; s++) issue(1'b0, c, s);
                for (int s = 0; s < 24; s++) issue(1'b1, c, s);
            end
        idle(3);

        do_reset(3'b001);
        for (int f = 0; f < 2; f++)
            for (int c = 0; c < 64; c++) begin
                for (int s = 0; s < 24; s++) issue(1'b0, c, s);
                for (int s = 0; s < 24; s++) issue(1'b1, c, s);
            end
        idle(3);

        do_reset(3'b010);
        for (int f = 0; f < 2; f++)
            for (int c = 0; c < 128; c++) begin
                for (int s = 12; s < 24; s++) issue(1'b0, c, s);
                for (int s = 0; s < 12; s++) issue(1'b1, c, s);
            end
        idle(3);

        do_reset(3'b100);               // R1: unlisted code selects mixed
        for (int f = 0; f < 2; f++)
            for (int c = 0; c < 128; c++) begin
                for (int s = 16; s < 24; s++) issue(1'b0, c, s);
                for (int s = 16; s < 24; s++) issue(1'b1, c, s);
                if (c % 4 == 0) begin
                    for (int s = 0; s < 16; s++) issue(1'b0, c, s);
                    for (int s = 0; s < 16; s++) issue(1'b1, c, s);
                end
            end
        idle(4);
        mon_on = 1'b0;
        report();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R11 watchdog act=hung exp=done");
        report();
        $finish;
    end

endmodule